// File: doc/BRIEF.md
# Streaming 16-to-12-bit component packer

This block sits on a wide data stream made of 16-bit components. Only the low 12 bits of each component are meaningful, so it discards the top nibble of every component and closes the gaps. The kept values go out on a stream of the same width with no padding between them. A sequence of four accepted input words becomes three output words. After the fourth input word the bit position is back on a word boundary, so a long transfer simply repeats this four-in, three-out pattern.

Both sides use a valid/ready handshake. An input word is taken on a clock edge where `in_valid` and `in_ready` are both high. An output word is taken on a clock edge where `out_valid` and `out_ready` are both high. When `out_valid` is high and `out_ready` is low, the output word and its flag stay frozen and `in_ready` is low, so back-pressure from the output reaches the input in the same cycle. With `out_ready` held high, one word per cycle passes in each direction.

A transfer may stop part way through a group. Raising `in_last` on the final input word makes the block emit whatever bits it still holds, zero-filled at the top, and mark the final output word with `out_last`. The next word then starts a new group at bit 0. The word width `WORD_W` must be a power of two no smaller than 64, and it defaults to 512.

Top module: `comp_packer16to12`

## Requirements
- R1: Every output bit comes from the low 12 bits of some input component. Component c of an input word occupies `in_data[16c+15:16c]`, and its bits 15..12 never reach the output, whatever their value.
- R2: Number the components from 0 in the order they arrive, counting from the most recent reset or `in_last`. The kept 12 bits of component j land at bits [12j+11:12j] of the concatenated output stream. Each output word carries the next WORD_W bits of that stream, with its bit 0 first.
- R3: Four accepted input words produce exactly three output words. The first word of a group produces no output. Each of the second, third and fourth words loads one output word in the cycle after it is accepted.
- R4: With `out_ready` held high and no `in_last`, `in_ready` stays high, so one word is accepted and one emitted per cycle.
- R5: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_data`/`out_last` keep their values in the next cycle.
- R6: Reset is synchronous and active high. It clears `out_valid`, the group position and the held bits, and it leaves `in_ready` high. The first word after reset is packed from bit 0.
- R7: If `in_last` comes with the first word of a group, that word produces one output word. This word holds its 3·WORD_W/4 kept bits, has zeros above them, and has `out_last` set.
- R8: If `in_last` comes with the second or third word of a group, the block first emits that word's output normally, with `out_last` low. It then emits one more word holding the leftover bits, zero-filled, with `out_last` high. `in_ready` is low while that extra word is pending.
- R9: If `in_last` comes with the fourth word of a group, the third output word of the group carries `out_last` high and no extra word follows.
- R10: After a word with `in_last`, the next accepted word begins a new group at bit 0 of the next output word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can take an input word this cycle |
| in_data | input | WORD_W | Input word, WORD_W/16 components |
| in_last | input | 1 | Marks the final word of a transfer |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream takes the output word |
| out_data | output | WORD_W | Packed output word |
| out_last | output | 1 | Marks the final output word of a transfer |

## Verification
The checker watches the handshake on every cycle. It checks that output data stays frozen and the input stays closed while the output is stalled, and that the first word of a group is silent while the three words after it each load an output. It also checks that an early `in_last` either closes the output at once or holds the input for one flush word, and that reset leaves the output empty and the input open. Only the bench scenarios can show that bit positions are correct. They compare the packed data against an independent bit-accumulator model, with random upper nibbles and random stalls on both sides, and they cover every end position and a reset in the middle of a group.

// File: rtl/cpk_pkg.sv
package cpk_pkg;
  localparam int SRC_BITS  = 16;
  localparam int KEEP_BITS = 12;
  typedef enum logic [1:0] {SLOT0, SLOT1, SLOT2, SLOT3} slot_e;
endpackage

// File: rtl/cpk_strip.sv
module cpk_strip #(
  parameter int WORD_W = 512
) (
  input  logic [WORD_W-1:0]                                  word,
  output logic [(WORD_W/cpk_pkg::SRC_BITS)*cpk_pkg::KEEP_BITS-1:0] kept
);
  import cpk_pkg::*;
  localparam int NCOMP  = WORD_W / SRC_BITS;
  localparam int DROP_W = SRC_BITS - KEEP_BITS;

  // Top nibbles have no destination; gathered only so every input bit is read.
  logic [NCOMP*DROP_W-1:0] unused_hi;

  for (genvar c = 0; c < NCOMP; c++) begin : g_comp
    assign kept[c*KEEP_BITS +: KEEP_BITS]  = word[c*SRC_BITS +: KEEP_BITS];
    assign unused_hi[c*DROP_W +: DROP_W]   = word[c*SRC_BITS+KEEP_BITS +: DROP_W];
  end
endmodule

// File: rtl/cpk_merge.sv
module cpk_merge #(
  parameter int WORD_W = 512
) (
  input  cpk_pkg::slot_e          slot,
  input  logic [3*WORD_W/4-1:0]   kept,
  input  logic [3*WORD_W/4-1:0]   resid,
  input  logic                    last,
  output logic                    emit,
  output logic [WORD_W-1:0]       word,
  output logic                    word_last,
  output logic [3*WORD_W/4-1:0]   resid_nxt,
  output cpk_pkg::slot_e          slot_nxt,
  output logic                    flush_nxt
);
  import cpk_pkg::*;
  localparam int Q  = WORD_W / 4;
  localparam int H  = WORD_W / 2;
  localparam int PW = 3 * Q;

  always_comb begin
    emit      = 1'b0;
    word      = '0;
    word_last = 1'b0;
    resid_nxt = resid;
    slot_nxt  = slot;
    flush_nxt = 1'b0;
    unique case (slot)
      SLOT0: begin
        if (last) begin
          emit      = 1'b1;
          word      = {{Q{1'b0}}, kept};
          word_last = 1'b1;
          resid_nxt = '0;
          slot_nxt  = SLOT0;
        end else begin
          resid_nxt = kept;
          slot_nxt  = SLOT1;
        end
      end
      SLOT1: begin
        emit      = 1'b1;
        word      = {kept[Q-1:0], resid};
        resid_nxt = {{Q{1'b0}}, kept[PW-1:Q]};
        slot_nxt  = last ? SLOT0 : SLOT2;
        flush_nxt = last;
      end
      SLOT2: begin
        emit      = 1'b1;
        word      = {kept[H-1:0], resid[H-1:0]};
        resid_nxt = {{H{1'b0}}, kept[PW-1:H]};
        slot_nxt  = last ? SLOT0 : SLOT3;
        flush_nxt = last;
      end
      SLOT3: begin
        emit      = 1'b1;
        word      = {kept, resid[Q-1:0]};
        word_last = last;
        resid_nxt = '0;
        slot_nxt  = SLOT0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/cpk_outreg.sv
module cpk_outreg #(
  parameter int WORD_W = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] ld_data,
  input  logic              ld_last,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic              out_last,
  output logic              free
);
  assign free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= ld_data;
      out_last  <= ld_last;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/comp_packer16to12.sv
module comp_packer16to12 #(
  parameter int WORD_W = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_last
);
  import cpk_pkg::*;
  localparam int Q  = WORD_W / 4;
  localparam int PW = 3 * Q;

  slot_e             slot_q, slot_d;
  logic [PW-1:0]     resid_q, resid_d, kept;
  logic              flush_q, flush_d;
  logic              emit, m_last, free, in_fire, flush_go, load, ld_last;
  logic [WORD_W-1:0] m_word, ld_data;

  cpk_strip #(.WORD_W(WORD_W)) u_strip (
    .word (in_data),
    .kept (kept)
  );

  cpk_merge #(.WORD_W(WORD_W)) u_merge (
    .slot      (slot_q),
    .kept      (kept),
    .resid     (resid_q),
    .last      (in_last),
    .emit      (emit),
    .word      (m_word),
    .word_last (m_last),
    .resid_nxt (resid_d),
    .slot_nxt  (slot_d),
    .flush_nxt (flush_d)
  );

  assign in_ready = !flush_q && free;
  assign in_fire  = in_valid && in_ready;
  assign flush_go = flush_q && free;
  assign load     = (in_fire && emit) || flush_go;
  assign ld_data  = flush_go ? {{Q{1'b0}}, resid_q} : m_word;
  assign ld_last  = flush_go ? 1'b1 : m_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q  <= SLOT0;
      resid_q <= '0;
      flush_q <= 1'b0;
    end else if (flush_go) begin
      resid_q <= '0;
      flush_q <= 1'b0;
    end else if (in_fire) begin
      slot_q  <= slot_d;
      resid_q <= resid_d;
      flush_q <= flush_d;
    end
  end

  cpk_outreg #(.WORD_W(WORD_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .ld_data   (ld_data),
    .ld_last   (ld_last),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last),
    .free      (free)
  );
endmodule

// File: rtl/cpk_checker.sv
module cpk_checker #(
  parameter int WORD_W = 512
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_last,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data,
  input logic              out_last
);
  logic [1:0] grp_in;
  logic       rst_q;
  logic       in_fire;

  assign in_fire = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) grp_in <= 2'd0;
    else if (in_fire) grp_in <= in_last ? 2'd0 : grp_in + 2'd1;
  end

  always_ff @(posedge clk) begin
    if (rst_q) begin
      AST_RESET_IDLE: assert (!out_valid && in_ready) else $error("reset state"); // R6
    end
    rst_q <= rst;
  end

  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last)); // R5

  AST_BLOCK_IN: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready); // R5

  AST_FIRST_SILENT: assert property (@(posedge clk) disable iff (rst)
    in_fire && grp_in == 2'd0 && !in_last |=> !out_valid); // R3

  AST_NEXT_EMITS: assert property (@(posedge clk) disable iff (rst)
    in_fire && grp_in != 2'd0 |=> out_valid); // R3

  AST_LONE_LAST: assert property (@(posedge clk) disable iff (rst)
    in_fire && in_last && grp_in == 2'd0 |=> out_valid && out_last); // R7

  AST_FLUSH_STALL: assert property (@(posedge clk) disable iff (rst)
    in_fire && in_last && (grp_in == 2'd1 || grp_in == 2'd2) |=> !in_ready && !out_last); // R8

  AST_FULL_LAST: assert property (@(posedge clk) disable iff (rst)
    in_fire && in_last && grp_in == 2'd3 |=> out_valid && out_last); // R9
endmodule

bind comp_packer16to12 cpk_checker #(.WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_last   (in_last),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_last  (out_last)
);

// File: tb/tb_comp_packer16to12.sv
`timescale 1ns/1ps
module tb_comp_packer16to12;
  localparam int W    = 512;
  localparam int NC   = W / 16;
  localparam int PW   = NC * 12;
  localparam int MAXW = 16;

  // [31:16] seed, [15:8] word count, [4] last on final word, [3:2] input stall, [1:0] output stall
  localparam logic [31:0] SCEN [0:7] = '{
    {16'h1A2B, 8'd8,  3'd0, 1'b0, 2'd0, 2'd0},
    {16'h3C4D, 8'd5,  3'd0, 1'b1, 2'd1, 2'd1},
    {16'h5E6F, 8'd6,  3'd0, 1'b1, 2'd0, 2'd2},
    {16'h7081, 8'd7,  3'd0, 1'b1, 2'd2, 2'd1},
    {16'h92A3, 8'd4,  3'd0, 1'b1, 2'd1, 2'd0},
    {16'hB4C5, 8'd12, 3'd0, 1'b0, 2'd0, 2'd3},
    {16'hD6E7, 8'd1,  3'd0, 1'b1, 2'd0, 2'd0},
    {16'hF809, 8'd2,  3'd0, 1'b1, 2'd0, 2'd0}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [W-1:0]  in_data = '0;
  logic          in_last = 1'b0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [W-1:0]  out_data;
  logic          out_last;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic [31:0] rng = 32'h1;
  logic prev_was_last = 1'b0;

  logic [W-1:0] in_words [0:MAXW-1];
  logic [W-1:0] exp_words [0:MAXW-1];
  logic         exp_last [0:MAXW-1];
  int           n_exp;

  always #4 clk = ~clk;

  comp_packer16to12 #(.WORD_W(W)) dut (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  function automatic logic [31:0] next_rand(input logic [31:0] s);
    logic [31:0] x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Reference: append low 12 bits of each component to a bit accumulator.
  task automatic build(input int n, input bit use_last);
    logic [2*W-1:0] acc = '0;
    int cnt = 0;
    n_exp = 0;
    for (int k = 0; k < n; k++) begin
      logic [PW-1:0] kp;
      for (int c = 0; c < NC; c++) kp[c*12 +: 12] = in_words[k][c*16 +: 12];
      acc = acc | ({{W{1'b0}}, {(W-PW){1'b0}}, kp} << cnt);
      cnt += PW;
      while (cnt >= W) begin
        exp_words[n_exp] = acc[W-1:0];
        exp_last[n_exp]  = 1'b0;
        n_exp++;
        acc = acc >> W;
        cnt -= W;
      end
    end
    if (use_last) begin
      if (cnt > 0) begin
        exp_words[n_exp] = acc[W-1:0];
        exp_last[n_exp]  = 1'b1;
        n_exp++;
      end else begin
        exp_last[n_exp-1] = 1'b1;
      end
    end
  endtask

  task automatic run_scen(input logic [15:0] seed, input int n, input bit use_last,
                          input int si, input int so);
    int pi = 0;
    int po = 0;
    int guard = 0;
    bit hold = 1'b0;
    bit ready_dropped = 1'b0;
    logic [W-1:0] held = '0;
    logic held_last = 1'b0;
    string ltag;
    rng = {16'h9E37, seed};
    for (int k = 0; k < n; k++) begin
      for (int c = 0; c < NC; c++) begin
        rng = next_rand(rng);
        in_words[k][c*16 +: 16] = {4'(rng[31:28] % 4'd15 + 4'd1), rng[11:0]};
      end
    end
    build(n, use_last);
    if (!use_last) ltag = "R3";
    else case ((n - 1) % 4)
      0: ltag = "R7";
      3: ltag = "R9";
      default: ltag = "R8";
    endcase
    while ((pi < n || po < n_exp) && guard < 2000) begin
      guard++;
      @(negedge clk);
      rng = next_rand(rng);
      out_ready = (int'(rng[3:0] % 4) >= so);
      in_valid  = (pi < n) && (int'(rng[9:6] % 4) >= si);
      in_data   = in_words[(pi < n) ? pi : 0];
      in_last   = use_last && (pi == n - 1);
      #1;
      if (hold) check(out_valid && out_data == held && out_last == held_last, "R5 hold", out_data, held);
      if (out_valid && !out_ready) check(!in_ready, "R5 input closed", W'(in_ready), '0);
      if (out_valid && out_ready) begin
        if (po < n_exp) begin
          check(out_data == exp_words[po], (po == 0 && prev_was_last) ? "R10" : "R1 R2",
                out_data, exp_words[po]);
          check(out_last == exp_last[po], ltag, W'(out_last), W'(exp_last[po]));
          if (exp_last[po] && (n - 1) % 4 == 0 && use_last)
            check(out_data[W-1:PW] == '0, "R7 zero fill", out_data, exp_words[po]);
        end else begin
          check(1'b0, "R3 extra word", out_data, '0);
        end
        po++;
      end
      if (in_valid && !in_ready && out_ready) ready_dropped = 1'b1;
      if (in_valid && in_ready) pi++;
      hold = out_valid && !out_ready;
      held = out_data;
      held_last = out_last;
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
    out_ready = 1'b1;
    #1;
    check(po == n_exp && guard < 2000, "R3 word count", W'(po), W'(n_exp));
    check(!out_valid, "R3 no trailing word", W'(out_valid), '0);
    if (!use_last && si == 0 && so == 0)
      check(!ready_dropped, "R4 full rate", W'(ready_dropped), '0);
    prev_was_last = use_last;
  endtask

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check(!out_valid && in_ready, "R6 reset state", W'({out_valid, in_ready}), W'(2'b01));

    for (int s = 0; s < 8; s++) begin
      run_scen(SCEN[s][31:16], int'(SCEN[s][15:8]), SCEN[s][4],
               int'(SCEN[s][3:2]), int'(SCEN[s][1:0]));
    end

    // R6: reset in the middle of a group discards held bits and position
    @(negedge clk);
    out_ready = 1'b0;
    in_valid  = 1'b1;
    in_last   = 1'b0;
    in_data   = {W{1'b1}};
    @(negedge clk);
    in_data   = {(W/2){2'b10}};
    @(negedge clk);
    in_valid  = 1'b0;
    #1;
    check(out_valid, "R6 pre-reset output pending", W'(out_valid), W'(1));
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(!out_valid && in_ready, "R6 mid-group reset", W'({out_valid, in_ready}), W'(2'b01));
    prev_was_last = 1'b0;
    run_scen(16'h0F0F, 4, 1'b0, 0, 0);
    run_scen(16'h2468, 3, 1'b1, 1, 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule